// File: doc/BRIEF.md
# Multi-Domain Register Frame Decoder

This block is the bus-facing front end of an interrupt routing service. It serves four configuration frames of 64 KiB each, one per physical interrupt domain, at fixed slot codes: Secure is 0, Non-secure is 1, EL3 is 2 and Realm is 3. A request names its slot, a 16-bit offset inside the frame, a size code, a direction and, for writes, data. The decoder checks that the domain exists and that the access is legal. It passes each accepted access to a per-domain register back end as a 32-bit or a 64-bit operation. It then returns read data and a response code one cycle later.

A 4-bit domain mask, one bit per slot code, is captured while reset is held. A domain that is cleared in the mask keeps its slot, and every access to that slot gets a decode error. Inside a present domain, a bad access never becomes a bus error. An illegal size or alignment, or an offset the back end does not claim, reads as zero, drops the write and answers OK. Each such access also produces a one-cycle event that carries the domain, offset, size code and direction, for tracing. A 64-bit register is presented to the back end either as one wide operation or as two separate 32-bit operations on its halves. The back end can therefore tie a write side effect to one chosen half.

Top module: `irs_frame_decoder`

## Requirements
- R1: The domain mask (bit n enables slot code n: 0 Secure, 1 Non-secure, 2 EL3, 3 Realm) is captured from `dom_cfg` on every clock edge while `rst_n` is low. Changes of `dom_cfg` after reset has been released have no effect.
- R2: A request to a slot whose mask bit is clear raises no back-end operation. It answers with `rsp_code` 2'b11 (decode error) and `rsp_rdata` zero.
- R3: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Only size 2 with `req_off[1:0]` zero and size 3 with `req_off[2:0]` zero are legal. In a present domain, an illegal access raises no back-end operation and answers `rsp_code` 2'b00 with `rsp_rdata` zero.
- R4: A legal access in a present domain raises `be_valid` in the same cycle, with the request's domain, offset and direction. An 8-byte access sets `be_wide` and passes all 64 data bits. A 4-byte access clears `be_wide` and passes the data in bits 31:0 (little-endian lanes), with bits 63:32 zero.
- R5: For a handled read, the response data is `be_rdata` for an 8-byte access and `be_rdata[31:0]` zero-extended for a 4-byte access. Every write answers with zero data.
- R6: A legal access in a present domain that the back end leaves unclaimed (`be_handled` low) answers `rsp_code` 2'b00 with `rsp_rdata` zero.
- R7: Each request accepted on a clock edge produces exactly one `rsp_valid` pulse on the next cycle. No response appears without a request.
- R8: Every refused or ignored access (R2, R3, R6) raises `ev_valid` in its response cycle, carrying the request's domain, offset, size code and direction. A handled access raises no event.
- R9: The two 32-bit halves of a 64-bit register reach the back end as separate narrow operations at offsets +0 and +4. A write to one half therefore triggers only the side effect the back end ties to that half or to the full-width write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_cfg | input | 4 | Implemented-domain mask, captured during reset |
| req_valid | input | 1 | Access request this cycle |
| req_dom | input | 2 | Frame slot / domain code |
| req_off | input | 16 | Byte offset inside the frame |
| req_size | input | 2 | Size code (0:1B 1:2B 2:4B 3:8B) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 00 OK, 11 decode error |
| rsp_rdata | output | 64 | Read data |
| be_valid | output | 1 | Back-end operation this cycle |
| be_dom | output | 2 | Domain of the operation |
| be_off | output | 16 | Offset of the operation |
| be_wide | output | 1 | 1 = 64-bit, 0 = 32-bit |
| be_write | output | 1 | Write strobe |
| be_wdata | output | 64 | Write data to the back end |
| be_handled | input | 1 | Back end claims the offset |
| be_rdata | input | 64 | Back-end read data |
| ev_valid | output | 1 | Ignored/refused access event |
| ev_dom | output | 2 | Event domain |
| ev_off | output | 16 | Event offset |
| ev_size | output | 2 | Event size code |
| ev_write | output | 1 | Event direction |

## Verification
The back-end operation is combinational from the request. The bench reads the `be_*` outputs one time unit after it drives a request at the falling edge, still inside the request cycle. Response data, response code and the event are each registered once, so they are due one cycle after the request. The bench samples them at the next falling edge, after the single rising edge that registers them. Back-end register state changes at that same edge. Readback through later requests shows whether a half-word write reached the right half and fired the right side effect.

// File: rtl/frm_pkg.sv
// Shared constants for the frame decoder: domain codes, size codes, response codes.
package frm_pkg;
    localparam int NUM_DOM  = 4;
    localparam int DOM_W    = $clog2(NUM_DOM);
    localparam int OFF_W    = 16;
    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;

    localparam logic [DOM_W-1:0] DOM_SECURE = 2'd0;
    localparam logic [DOM_W-1:0] DOM_NONSEC = 2'd1;
    localparam logic [DOM_W-1:0] DOM_EL3    = 2'd2;
    localparam logic [DOM_W-1:0] DOM_REALM  = 2'd3;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } size_code_t;

    typedef enum logic [1:0] {
        RSP_OK     = 2'b00,
        RSP_DECERR = 2'b11
    } rsp_code_t;
endpackage

// File: rtl/frm_dom_mask.sv
// Holds the implemented-domain mask.
// Assumes: mask is only loaded while reset is asserted; afterwards it is frozen.
module frm_dom_mask #(
    parameter int NUM_DOM = 4,
    localparam int DOM_W = $clog2(NUM_DOM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] cfg,
    input  logic [DOM_W-1:0]   dom,
    output logic               present
);
    logic [NUM_DOM-1:0] mask_q;

    // Capture configuration during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= cfg;
    end

    // Look up the addressed slot.
    always_comb present = mask_q[dom];
endmodule

// File: rtl/frm_size_check.sv
// Classifies an access by size and alignment.
// Assumes: only 4-byte and 8-byte naturally aligned accesses are legal.
module frm_size_check #(
    parameter int OFF_W = 16
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             legal,
    output logic             wide
);
    import frm_pkg::*;

    // Legal when the size is 4 or 8 bytes and the offset is aligned to it.
    always_comb begin
        legal = 1'b0;
        wide  = 1'b0;
        unique case (size_code_t'(size))
            SZ_B4: legal = (off[1:0] == 2'b00);
            SZ_B8: begin
                legal = (off[2:0] == 3'b000);
                wide  = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/frm_rsp_stage.sv
// Registers the response and the trace event one cycle after the request.
// Assumes: at most one request per cycle; no back-pressure on the response.
module frm_rsp_stage #(
    parameter int DOM_W  = 2,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic              decerr,
    input  logic [DATA_W-1:0] rdata_d,
    input  logic              ev_d,
    input  logic [DOM_W-1:0]  dom_d,
    input  logic [OFF_W-1:0]  off_d,
    input  logic [1:0]        size_d,
    input  logic              write_d,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ev_valid,
    output logic [DOM_W-1:0]  ev_dom,
    output logic [OFF_W-1:0]  ev_off,
    output logic [1:0]        ev_size,
    output logic              ev_write
);
    import frm_pkg::*;

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_fire;
            rsp_code  <= (req_fire && decerr) ? RSP_DECERR : RSP_OK;
            rsp_rdata <= req_fire ? rdata_d : '0;
        end
    end

    // Trace event register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_dom   <= '0;
            ev_off   <= '0;
            ev_size  <= '0;
            ev_write <= 1'b0;
        end else begin
            ev_valid <= req_fire && ev_d;
            ev_dom   <= dom_d;
            ev_off   <= off_d;
            ev_size  <= size_d;
            ev_write <= write_d;
        end
    end
endmodule

// File: rtl/irs_frame_decoder.sv
// Front end for four fixed per-domain configuration frames.
// Assumes: back end answers be_handled/be_rdata combinationally in the
// cycle of be_valid; responses are always accepted.
module irs_frame_decoder #(
    parameter int NUM_DOM = frm_pkg::NUM_DOM,
    parameter int OFF_W   = frm_pkg::OFF_W,
    parameter int DATA_W  = frm_pkg::DATA_W,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] dom_cfg,
    input  logic               req_valid,
    input  logic [DOM_W-1:0]   req_dom,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               be_valid,
    output logic [DOM_W-1:0]   be_dom,
    output logic [OFF_W-1:0]   be_off,
    output logic               be_wide,
    output logic               be_write,
    output logic [DATA_W-1:0]  be_wdata,
    input  logic               be_handled,
    input  logic [DATA_W-1:0]  be_rdata,
    output logic               ev_valid,
    output logic [DOM_W-1:0]   ev_dom,
    output logic [OFF_W-1:0]   ev_off,
    output logic [1:0]         ev_size,
    output logic               ev_write
);
    logic present, legal, wide, fire;
    logic [DATA_W-1:0] rdata_d;
    logic ev_d;

    frm_dom_mask #(.NUM_DOM(NUM_DOM)) u_mask (
        .clk(clk), .rst_n(rst_n), .cfg(dom_cfg), .dom(req_dom), .present(present)
    );

    frm_size_check #(.OFF_W(OFF_W)) u_size (
        .size(req_size), .off(req_off), .legal(legal), .wide(wide)
    );

    // Requests are only taken out of reset.
    always_comb fire = req_valid && rst_n;

    // Back-end operation: narrow data rides in the low lanes.
    always_comb begin
        be_valid = fire && present && legal;
        be_dom   = req_dom;
        be_off   = req_off;
        be_wide  = wide;
        be_write = req_write;
        be_wdata = wide ? req_wdata : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};
    end

    // Read data and event classification.
    always_comb begin
        rdata_d = '0;
        if (be_valid && be_handled && !req_write)
            rdata_d = wide ? be_rdata : {{HALF_W{1'b0}}, be_rdata[HALF_W-1:0]};
        ev_d = !(be_valid && be_handled);
    end

    frm_rsp_stage #(.DOM_W(DOM_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .req_fire(fire), .decerr(!present),
        .rdata_d(rdata_d), .ev_d(ev_d), .dom_d(req_dom), .off_d(req_off),
        .size_d(req_size), .write_d(req_write),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .ev_valid(ev_valid), .ev_dom(ev_dom), .ev_off(ev_off),
        .ev_size(ev_size), .ev_write(ev_write)
    );
endmodule

// File: rtl/irs_frame_decoder_chk.sv
// Property checker for irs_frame_decoder, attached by bind.
module irs_frame_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code,
    input logic [63:0] rsp_rdata,
    input logic        be_valid,
    input logic        be_wide,
    input logic        be_handled,
    input logic        ev_valid
);
    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    decerr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'b11) |-> (rsp_rdata == 64'd0));
    // R4
    be_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> req_valid);
    // R4
    wide_is_8byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (be_wide == (req_size == 2'd3)));
    // R8
    handled_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_handled) |=> !ev_valid);
    // R8
    event_in_rsp_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> rsp_valid);
endmodule

bind irs_frame_decoder irs_frame_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .be_valid(be_valid), .be_wide(be_wide), .be_handled(be_handled),
    .ev_valid(ev_valid)
);

// File: tb/irs_frame_decoder_tb.sv
// Bench: random plus directed accesses against a modelled back end.
module irs_frame_decoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] dom_cfg = 4'b0010;
    logic req_valid = 1'b0;
    logic [1:0] req_dom = '0;
    logic [15:0] req_off = '0;
    logic [1:0] req_size = '0;
    logic req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, be_valid, be_wide, be_write, ev_valid, ev_write;
    logic [1:0] rsp_code, be_dom, ev_dom, ev_size;
    logic [63:0] rsp_rdata, be_wdata, be_rdata;
    logic [15:0] be_off, ev_off;
    logic be_handled;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    irs_frame_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .dom_cfg(dom_cfg),
        .req_valid(req_valid), .req_dom(req_dom), .req_off(req_off),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .be_valid(be_valid), .be_dom(be_dom), .be_off(be_off), .be_wide(be_wide),
        .be_write(be_write), .be_wdata(be_wdata), .be_handled(be_handled),
        .be_rdata(be_rdata), .ev_valid(ev_valid), .ev_dom(ev_dom),
        .ev_off(ev_off), .ev_size(ev_size), .ev_write(ev_write)
    );

    // Back-end model: 64-bit reg at 0x0 (halves 0x0/0x4), 32-bit reg at 0x8,
    // read-only side-effect counter at 0xC; high half or wide write fires it.
    logic [63:0] m_a [4];
    logic [31:0] m_b [4];
    logic [31:0] m_f [4];
    // Reference copies the bench expects.
    logic [63:0] r_a [4];
    logic [31:0] r_b [4];
    logic [31:0] r_f [4];
    logic [3:0]  r_mask;

    function automatic logic claims(logic wide, logic [15:0] off, logic wr);
        if (wide) return off == 16'h0;
        return off == 16'h0 || off == 16'h4 || off == 16'h8 || (off == 16'hC && !wr);
    endfunction

    // Model read path.
    always_comb begin
        be_handled = be_valid && claims(be_wide, be_off, be_write);
        be_rdata = '0;
        if (be_wide) be_rdata = m_a[be_dom];
        else case (be_off)
            16'h0: be_rdata = {32'hDEAD_BEEF, m_a[be_dom][31:0]};
            16'h4: be_rdata = {32'hDEAD_BEEF, m_a[be_dom][63:32]};
            16'h8: be_rdata = {32'hDEAD_BEEF, m_b[be_dom]};
            16'hC: be_rdata = {32'hDEAD_BEEF, m_f[be_dom]};
            default: be_rdata = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    end

    // Model write path.
    always @(posedge clk) begin
        if (rst_n && be_valid && be_handled && be_write) begin
            if (be_wide) begin
                m_a[be_dom] <= be_wdata;
                m_f[be_dom] <= m_f[be_dom] + 1;
            end else case (be_off)
                16'h0: m_a[be_dom][31:0] <= be_wdata[31:0];
                16'h4: begin
                    m_a[be_dom][63:32] <= be_wdata[31:0];
                    m_f[be_dom] <= m_f[be_dom] + 1;
                end
                16'h8: m_b[be_dom] <= be_wdata[31:0];
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        @(negedge clk);
        rst_n = 1'b0;
        dom_cfg = cfg;
        r_mask = cfg;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access: drive at negedge, check back end in-cycle, response one cycle later.
    task automatic access(input logic [1:0] dom, input logic [15:0] off,
                          input logic [1:0] sz, input logic wr, input logic [63:0] wd);
        logic pres, leg, wide, clm;
        logic [63:0] exp_rd, exp_wd;
        pres = r_mask[dom];
        wide = (sz == 2'd3);
        leg = (sz == 2'd2 && off[1:0] == 2'b00) || (sz == 2'd3 && off[2:0] == 3'b000);
        clm = pres && leg && claims(wide, off, wr);
        exp_wd = wide ? wd : {32'd0, wd[31:0]};
        exp_rd = '0;
        if (clm && !wr) begin
            if (wide) exp_rd = r_a[dom];
            else case (off)
                16'h0: exp_rd = {32'd0, r_a[dom][31:0]};
                16'h4: exp_rd = {32'd0, r_a[dom][63:32]};
                16'h8: exp_rd = {32'd0, r_b[dom]};
                default: exp_rd = {32'd0, r_f[dom]};
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_dom = dom; req_off = off;
        req_size = sz; req_write = wr; req_wdata = wd;
        #1;
        // R2 R3 R4: operation forwarded only for legal accesses in present domains
        chk(be_valid == (pres && leg), "R4 be_valid", {63'd0, be_valid}, {63'd0, pres && leg});
        if (pres && leg) begin
            chk(be_dom == dom && be_off == off && be_write == wr && be_wide == wide,
                "R4 be fields", {be_dom, be_off, be_write, be_wide}, {dom, off, wr, wide});
            if (wr) chk(be_wdata == exp_wd, "R4 be_wdata", be_wdata, exp_wd);
        end
        if (clm && wr) begin
            if (wide) begin r_a[dom] = wd; r_f[dom] = r_f[dom] + 1; end
            else case (off)
                16'h0: r_a[dom][31:0] = wd[31:0];
                16'h4: begin r_a[dom][63:32] = wd[31:0]; r_f[dom] = r_f[dom] + 1; end
                16'h8: r_b[dom] = wd[31:0];
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R7 response one cycle later
        chk(rsp_valid == 1'b1, "R7 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        // R2 code
        chk(rsp_code == (pres ? 2'b00 : 2'b11), "R2 rsp_code", {62'd0, rsp_code}, pres ? 64'd0 : 64'd3);
        // R5 R6 data
        chk(rsp_rdata == exp_rd, "R5/R6 rsp_rdata", rsp_rdata, exp_rd);
        // R8 event
        chk(ev_valid == !clm, "R8 ev_valid", {63'd0, ev_valid}, {63'd0, !clm});
        if (!clm)
            chk(ev_dom == dom && ev_off == off && ev_size == sz && ev_write == wr,
                "R8 ev fields", {ev_dom, ev_off, ev_size, ev_write}, {dom, off, sz, wr});
    endtask

    task automatic random_run(input int n);
        logic [15:0] offs [8];
        offs = '{16'h0, 16'h4, 16'h8, 16'hC, 16'h2, 16'h10, 16'hFFF8, 16'h6};
        for (int i = 0; i < n; i++)
            access($urandom_range(3, 0), offs[$urandom_range(7, 0)],
                   $urandom_range(3, 0), $urandom_range(1, 0),
                   {$urandom, $urandom});
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1234_5678);
        for (int d = 0; d < 4; d++) begin
            m_a[d] = '0; m_b[d] = '0; m_f[d] = '0;
            r_a[d] = '0; r_b[d] = '0; r_f[d] = '0;
        end
        r_mask = 4'b0010;
        do_reset(4'b0010);
        #1;
        // R7 reset state
        chk(!rsp_valid && !ev_valid && !be_valid, "R7 reset state",
            {61'd0, rsp_valid, ev_valid, be_valid}, 64'd0);
        // R1: mask changes after reset ignored
        dom_cfg = 4'b1111;
        access(2'd0, 16'h0, 2'd3, 1'b0, 64'd0);           // R1 R2 secure absent
        access(2'd3, 16'h8, 2'd2, 1'b1, 64'h55);          // R2 realm absent write
        // R9 half writes and side effect
        access(2'd1, 16'h0, 2'd2, 1'b1, 64'hAAAA_BBBB_1111_2222); // low half
        access(2'd1, 16'hC, 2'd2, 1'b0, 64'd0);           // R9 counter still 0
        access(2'd1, 16'h4, 2'd2, 1'b1, 64'h3333_4444);   // high half fires
        access(2'd1, 16'hC, 2'd2, 1'b0, 64'd0);           // R9 counter 1
        access(2'd1, 16'h0, 2'd3, 1'b0, 64'd0);           // R5 wide read
        access(2'd1, 16'h0, 2'd3, 1'b1, 64'h0123_4567_89AB_CDEF); // wide write fires
        access(2'd1, 16'h4, 2'd2, 1'b0, 64'd0);           // R5 high half read
        // R3 illegal sizes/alignment
        access(2'd1, 16'h0, 2'd0, 1'b1, 64'hFF);
        access(2'd1, 16'h0, 2'd1, 1'b0, 64'd0);
        access(2'd1, 16'h4, 2'd3, 1'b0, 64'd0);
        access(2'd1, 16'h2, 2'd2, 1'b1, 64'h77);
        access(2'd1, 16'h0, 2'd3, 1'b0, 64'd0);           // R3 data unchanged
        // R6 reserved
        access(2'd1, 16'h10, 2'd2, 1'b0, 64'd0);
        access(2'd1, 16'h8, 2'd3, 1'b0, 64'd0);
        access(2'd1, 16'hC, 2'd2, 1'b1, 64'h9);
        random_run(300);
        // R1 other configurations
        do_reset(4'b1111);
        random_run(300);
        do_reset(4'b0101);
        random_run(300);
        // R7 no response without request
        @(negedge clk);
        chk(!rsp_valid && !ev_valid, "R7 idle", {62'd0, rsp_valid, ev_valid}, 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 64'd1, 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule